// File: doc/BRIEF.md
# Cascaded Two-Stage Modular Adder Datapath

This block computes the modular sum of two multi-precision integers, (X + Y) mod N, using one pass through two chained arithmetic stages. The first stage is an adder/subtracter whose operands come from a selector. The selector can form A+B, A+A, B+B, A−B or B−A from the two word inputs. The second stage subtracts the modulus word N from the first-stage word. The block records the carry of the first stage and the borrow of the second stage. From these two flags it picks either the plain sum or the sum minus N. Each stage is a single adder, so the longest combinational path through the block is two word-wide additions.

Operands wider than one word enter as a sequence of words, least significant word first. The first word is marked by `in_first` and the final word by `in_last`. Between words, the stage-one carry and the stage-two borrow are held in flag registers. The choice between the two candidates can only be made once the most significant word has been seen. For that reason both candidate words are kept in a small buffer for every word position. When the final word has been taken in, the chosen result is streamed out, one word per cycle, least significant word first. A controller that sequences higher-level operations (multiplication by repeated doubling, exponentiation and so on) drives this block one modular addition at a time.

Top module: `mod_add_dp`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low.
- R2: `in_op` is sampled on the first word and selects the stage-one pairing. The codes are 0 = A+B, 1 = A+A, 2 = B+B, 3 = A−B and 4 = B−A.
- R3: For the three addition codes, the result is the sum minus N whenever the sum is greater than or equal to N. Otherwise the result is the sum unchanged. A sum exactly equal to N gives zero.
- R4: When the addition carries out of the most significant word, the result is the sum minus N, truncated to the operand width. This holds even though the stage-two word subtraction borrows.
- R5: The two subtraction codes are never reduced. The result is the difference modulo 2^(W·k), where W is the word width and k is the number of words.
- R6: For operations of more than one word, the carry and borrow are passed from each word to the next. One choice between the two candidates, made from the flags of the most significant word, applies to every result word.
- R7: The result words appear on `out_word` with `out_valid` high. The first word appears in the cycle after the clock edge that takes in the final input word. Words follow one per cycle, least significant first, and `out_last` is high only on the most significant word.
- R8: While `out_valid` is high, `in_valid` is ignored. No word presented during that time is taken in or starts a new operation.
- R9: A word that fills the last buffer slot (word index MAXW−1) ends the operation even when `in_last` is low.
- R10: A word with `in_first` high starts a new operation from index 0 with cleared chain flags. It discards any unfinished operation.
- R11: The unused codes 5, 6 and 7 behave as A+B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input word is presented |
| in_first | input | 1 | Least significant word of a new operation |
| in_last | input | 1 | Most significant word of the operation |
| in_op | input | 3 | Pairing code, sampled with the first word |
| in_a | input | W | Word of operand A |
| in_b | input | W | Word of operand B |
| in_n | input | W | Word of modulus N |
| out_valid | output | 1 | A result word is on `out_word` |
| out_last | output | 1 | This result word is the most significant |
| out_word | output | W | Result word |

## Verification
The hardest case to reach is one where the low-order word and the full-width value disagree on the reduction decision. An example is a low word whose stage-two subtraction borrows while the whole sum still exceeds N. Another is a sum that overflows the word so that the stage-two borrow must be overruled by the carry. The stimulus reaches these cases in two ways. Some operands place the carry exactly at the word boundary. Others are two-word operands chosen so that only the most significant word decides. A 4-word operation is also sent without `in_last`, to reach the full-buffer ending. Input words are driven throughout a result burst to show that they are ignored.

// File: rtl/mad_pkg.sv
package mad_pkg;

  typedef enum logic [2:0] {
    OP_APB = 3'd0,
    OP_APA = 3'd1,
    OP_BPB = 3'd2,
    OP_AMB = 3'd3,
    OP_BMA = 3'd4
  } mad_op_e;

  // Pairings that subtract in stage one and bypass reduction.
  function automatic logic op_is_sub(input logic [2:0] op);
    return (op == OP_AMB) || (op == OP_BMA);
  endfunction

endpackage

// File: rtl/mad_stage1.sv
module mad_stage1 #(
  parameter int W = 128
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  import mad_pkg::*;

  function automatic logic [W:0] add_c(input logic [W-1:0] x,
                                       input logic [W-1:0] y,
                                       input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W-1:0] opx, opy;

  always_comb begin
    unique case (op)
      OP_APA:  begin opx = a; opy = a;  end
      OP_BPB:  begin opx = b; opy = b;  end
      OP_AMB:  begin opx = a; opy = ~b; end
      OP_BMA:  begin opx = b; opy = ~a; end
      default: begin opx = a; opy = b;  end
    endcase
  end

  assign {cout, sum} = add_c(opx, opy, cin);

endmodule

// File: rtl/mad_stage2.sv
module mad_stage2 #(
  parameter int W = 128
) (
  input  logic [W-1:0] s,
  input  logic [W-1:0] n,
  input  logic         cin,
  output logic [W-1:0] d,
  output logic         cout
);
  // cout high means no borrow out of this word.
  function automatic logic [W:0] sub_c(input logic [W-1:0] x,
                                       input logic [W-1:0] y,
                                       input logic c);
    return {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, c};
  endfunction

  assign {cout, d} = sub_c(s, n, cin);

endmodule

// File: rtl/mad_drain.sv
module mad_drain #(
  parameter int W    = 128,
  parameter int MAXW = 4,
  localparam int IW  = (MAXW > 1) ? $clog2(MAXW) : 1,
  localparam int LW  = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  sum_w,
  input  logic [W-1:0]  dif_w,
  input  logic          start,
  input  logic [LW-1:0] len_in,
  input  logic          sel_in,
  output logic          busy,
  output logic          last,
  output logic          sel,
  output logic [W-1:0]  word
);
  logic [W-1:0]  sbuf [MAXW];
  logic [W-1:0]  dbuf [MAXW];
  logic [IW-1:0] rd_q;
  logic [LW-1:0] len_q;
  logic          busy_q, sel_q;

  genvar g;
  generate
    for (g = 0; g < MAXW; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && wr_idx == IW'(g)) begin
          sbuf[g] <= sum_w;
          dbuf[g] <= dif_w;
        end
      end
    end
  endgenerate

  logic at_end;
  assign at_end = ({{(LW-IW){1'b0}}, rd_q} == len_q - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= '0;
      len_q  <= '0;
      sel_q  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      rd_q   <= '0;
      len_q  <= len_in;
      sel_q  <= sel_in;
    end else if (busy_q) begin
      rd_q <= rd_q + IW'(1);
      if (at_end) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign sel  = sel_q;
  assign last = busy_q && at_end;
  assign word = busy_q ? (sel_q ? dbuf[rd_q] : sbuf[rd_q]) : '0;

endmodule

// File: rtl/mod_add_dp.sv
module mod_add_dp #(
  parameter int W    = 128,
  parameter int MAXW = 4,
  localparam int IW  = (MAXW > 1) ? $clog2(MAXW) : 1,
  localparam int LW  = $clog2(MAXW + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         in_last,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_n,
  output logic         out_valid,
  output logic         out_last,
  output logic [W-1:0] out_word
);
  import mad_pkg::*;

  logic [2:0]    op_q, op_eff;
  logic [IW-1:0] idx_q, idx;
  logic          c1_q, c2_q;
  logic          cin1, cin2;
  logic [W-1:0]  sum_w, dif_w;
  logic          c1, c2;
  logic          busy, accept, accept_last, op_sub, reduce, drain_sel;
  logic [LW-1:0] len;

  // Chain flags are ignored (treated as cleared) on a first word.
  assign op_eff = in_first ? in_op : op_q;
  assign idx    = in_first ? '0 : idx_q;
  assign op_sub = op_is_sub(op_eff);
  assign cin1   = in_first ? op_sub : c1_q;
  assign cin2   = in_first ? 1'b1   : c2_q;

  mad_stage1 #(.W(W)) u_s1 (
    .a(in_a), .b(in_b), .op(op_eff), .cin(cin1), .sum(sum_w), .cout(c1)
  );

  mad_stage2 #(.W(W)) u_s2 (
    .s(sum_w), .n(in_n), .cin(cin2), .d(dif_w), .cout(c2)
  );

  assign accept      = in_valid && !busy;
  assign accept_last = accept && (in_last || idx == IW'(MAXW - 1));
  // Reduce on carry out, or when the subtraction of N did not borrow.
  assign reduce      = !op_sub && (c1 || c2);
  assign len         = {{(LW-IW){1'b0}}, idx} + LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      idx_q <= '0;
      c1_q  <= 1'b0;
      c2_q  <= 1'b0;
    end else if (accept) begin
      op_q  <= op_eff;
      c1_q  <= c1;
      c2_q  <= c2;
      idx_q <= accept_last ? '0 : idx + IW'(1);
    end
  end

  mad_drain #(.W(W), .MAXW(MAXW)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept), .wr_idx(idx), .sum_w(sum_w), .dif_w(dif_w),
    .start(accept_last), .len_in(len), .sel_in(reduce),
    .busy(busy), .last(out_last), .sel(drain_sel), .word(out_word)
  );

  assign out_valid = busy;

endmodule

// File: rtl/mad_chk.sv
module mad_chk (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic accept_last,
  input logic op_sub,
  input logic drain_sel,
  input logic out_valid,
  input logic out_last
);
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !accept);
  // R7
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R7
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R7
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept_last));
  // R6
  one_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(drain_sel));
  // R5
  sub_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && $past(op_sub)) |-> !drain_sel);
endmodule

bind mod_add_dp mad_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .accept_last(accept_last),
  .op_sub(op_sub), .drain_sel(drain_sel),
  .out_valid(out_valid), .out_last(out_last)
);

// File: tb/mod_add_dp_bench.sv
module mod_add_dp_bench;
  localparam int W    = 128;
  localparam int MAXW = 4;
  localparam int XW   = W * MAXW + 1;
  typedef logic [XW-1:0] wide_t;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] n;
    logic [W-1:0] exp;
  } vec_t;

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] TOP  = {1'b1, {(W-1){1'b0}}};

  localparam vec_t VECS [0:10] = '{
    '{3'd0, 128'd5,  128'd7,  128'd100, 128'd12},   // R2 A+B below N
    '{3'd0, 128'd60, 128'd50, 128'd100, 128'd10},   // R3 reduced
    '{3'd1, 128'd60, 128'd0,  128'd100, 128'd20},   // R2 A+A
    '{3'd2, 128'd0,  128'd30, 128'd100, 128'd60},   // R2 B+B
    '{3'd3, 128'd10, 128'd3,  128'd5,   128'd7},    // R5 A-B not reduced
    '{3'd4, 128'd10, 128'd3,  128'd5,   ONES - 128'd6}, // R5 B-A wraps
    '{3'd0, TOP,     TOP,     ONES,     128'd1},    // R4 carry overrules borrow
    '{3'd0, ONES,    128'd1,  128'd3,   ONES - 128'd2}, // R4
    '{3'd0, 128'd40, 128'd60, 128'd100, 128'd0},    // R3 equal to N
    '{3'd6, 128'd1,  128'd2,  128'd2,   128'd1},    // R11 alias of A+B
    '{3'd0, 128'd49, 128'd50, 128'd100, 128'd99}    // R3 one below N
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [2:0]   in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0, in_n = '0;
  logic         out_valid, out_last;
  logic [W-1:0] out_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mod_add_dp #(.W(W), .MAXW(MAXW)) u_mod_add_dp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_n(in_n),
    .out_valid(out_valid), .out_last(out_last), .out_word(out_word)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(input logic f, input logic l, input logic [2:0] op,
                      input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] n);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_last = l; in_op = op;
    in_a = a; in_b = b; in_n = n;
  endtask

  // Expected result computed from the requirement text (full-width math).
  function automatic wide_t model(input logic [2:0] op, input int k,
                                  input wide_t x, input wide_t y, input wide_t n);
    wide_t mask, s;
    mask = (wide_t'(1) << (k * W)) - wide_t'(1);
    unique case (op)
      3'd1: s = x + x;
      3'd2: s = y + y;
      3'd3: return (x - y) & mask;
      3'd4: return (y - x) & mask;
      default: s = x + y;
    endcase
    if (s >= n) s = s - n;
    return s & mask;
  endfunction

  // Starts at the negedge where the final input word is on the pins.
  task automatic get_burst(input int k, input wide_t expv, input string tag,
                           input logic keep);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (keep) begin
          in_first = 1'b1; in_last = 1'b1; in_op = 3'd0;
          in_a = ONES; in_b = ONES; in_n = 128'd9;
        end else in_valid = 1'b0;
      end
      check(out_valid && out_word == expv[i*W +: W] && out_last == (i == k - 1),
            tag, out_word, expv[i*W +: W]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(!out_valid && !out_last, tag, W'(out_valid), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wide_t x, y, n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!out_valid && !out_last, "R1", W'({out_valid, out_last}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1", W'(out_valid), '0);

    // Single-word table (R2 R3 R4 R5 R11)
    for (int v = 0; v < 11; v++) begin
      send(1'b1, 1'b1, VECS[v].op, VECS[v].a, VECS[v].b, VECS[v].n);
      get_burst(1, wide_t'(VECS[v].exp), $sformatf("R2/R3/R4/R5/R11 vec %0d", v), 1'b0);
    end

    // R6: low word borrows in stage two, full value still reduces
    x = '0; y = '0; n = '0;
    x[W-1:0] = ONES; x[2*W-1:W] = 128'd1;
    y[W-1:0] = 128'd1;
    n[W-1:0] = 128'd5; n[2*W-1:W] = 128'd1;
    send(1'b1, 1'b0, 3'd0, x[W-1:0], y[W-1:0], n[W-1:0]);
    send(1'b0, 1'b1, 3'd0, x[2*W-1:W], y[2*W-1:W], n[2*W-1:W]);
    get_burst(2, model(3'd0, 2, x, y, n), "R6 reduce", 1'b0);

    // R6: two-word sum below N keeps plain sum
    n[2*W-1:W] = 128'd3;
    send(1'b1, 1'b0, 3'd0, x[W-1:0], y[W-1:0], n[W-1:0]);
    send(1'b0, 1'b1, 3'd0, x[2*W-1:W], y[2*W-1:W], n[2*W-1:W]);
    get_burst(2, model(3'd0, 2, x, y, n), "R6 keep", 1'b0);

    // R5 R6: two-word subtraction borrows across the word boundary
    x = '0; y = '0; n = '1;
    x[W-1:0] = 128'd5; y[W-1:0] = 128'd7;
    send(1'b1, 1'b0, 3'd3, x[W-1:0], y[W-1:0], ONES);
    send(1'b0, 1'b1, 3'd3, '0, '0, ONES);
    get_burst(2, model(3'd3, 2, x, y, n), "R5 multiword", 1'b0);

    // R8: input words held valid during the burst are ignored
    x = '0; y = '0; n = '0;
    x[W-1:0] = 128'd70; y[W-1:0] = 128'd40; n[W-1:0] = 128'd100;
    x[2*W-1:W] = 128'd0; n[2*W-1:W] = 128'd0;
    send(1'b1, 1'b0, 3'd0, x[W-1:0], y[W-1:0], n[W-1:0]);
    send(1'b0, 1'b1, 3'd0, '0, '0, '0);
    get_burst(2, model(3'd0, 2, x, y, n), "R8", 1'b1);
    @(negedge clk);
    check(!out_valid, "R8 no new op", W'(out_valid), '0);

    // R9: four words with in_last low end at the full buffer (B+B)
    x = '0; y = '0; n = '0;
    for (int i = 0; i < MAXW; i++) begin
      y[i*W +: W] = ONES - W'(i);
      n[i*W +: W] = ONES;
    end
    n[XW-1] = 1'b0;
    for (int i = 0; i < MAXW; i++)
      send(i == 0, 1'b0, 3'd2, '0, y[i*W +: W], n[i*W +: W]);
    get_burst(MAXW, model(3'd2, MAXW, x, y, n), "R9", 1'b0);

    // R10: a new first word discards a partial operation and its flags
    send(1'b1, 1'b0, 3'd0, ONES, ONES, 128'd0);
    send(1'b1, 1'b1, 3'd0, 128'd1, 128'd1, 128'd100);
    get_burst(1, wide_t'(128'd2), "R10", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule